// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of a MAC-to-memory engine. Incoming frames come in as a byte stream. Software prepares a ring of 64-bit buffer descriptors in a small descriptor memory. Each descriptor carries a status word, a length and a buffer address. A descriptor belongs to the engine only while its empty flag is set.

The engine fetches the current descriptor and waits for a frame. It writes the frame's bytes one per cycle into the buffer that the descriptor names. When the frame ends, it writes the descriptor back with the ownership flag cleared, the frame length and the error flags. It then moves to the next descriptor, or back to entry 0 when the closed descriptor carries the wrap flag.

When the engine reaches a descriptor that software still owns, it stops. Every frame that starts while it is not ready is discarded and counted. A strobe on the activate input makes the engine read the same descriptor again. Each closed frame sets a bit in an event register. That register is cleared by writing ones, and it is masked onto a single interrupt line.

Descriptor layout, bits [63:0]:

| Bits | Field |
|---|---|
| [63:48] | status word |
| [47:32] | length |
| [31:0] | buffer byte address |

Status word bit positions:

| Bit | Meaning |
|---|---|
| 15 | empty (owned by the engine) |
| 13 | wrap |
| 11 | last buffer of the frame |
| 5 | frame too long |
| 4 | frame length not a whole number of octets |
| 3 | frame too short |
| 2 | CRC error |
| 1 | FIFO overrun |
| 0 | late collision |

Top module: `rxring_engine`

## Requirements
- R1: After reset the engine is halted. It makes no descriptor or buffer access. `evt_q` is 0, `irq` is 0 and `drop_count` is 0.
- R2: A pulse on `act_wr` while halted reads the current descriptor. If its status bit 15 (empty) is set, the next frame's bytes are written one per cycle to buffer address + 0, +1, +2, and so on. No buffer write happens in a cycle that accesses the descriptor memory.
- R3: One cycle after the frame's final byte is accepted, the engine writes the descriptor back as follows:
  - status bit 15 is cleared and status bit 11 (last) is set;
  - status bit 13 (wrap) keeps its value;
  - the length field holds the number of bytes received, including the 4-byte FCS;
  - the address field is unchanged.
- R4: After closing a descriptor, the engine fetches the next index, or index 0 when the closed descriptor had status bit 13 set.
- R5: A fetched descriptor with bit 15 clear halts the engine. Each frame that starts while the engine is not ready is dropped without any buffer write, and `drop_count` rises by exactly one per dropped frame.
- R6: While halted, an `act_wr` pulse re-reads the same descriptor index, because the index is not advanced past the stall.
- R7: Status bit 3 is set when the length is below 64. Status bit 5 is set when the length is above 1518. Bytes at buffer offsets of 1520 or more are not written.
- R8: Sideband `rx_flags`, sampled with the final byte, map into the status word as follows:

  | `rx_flags` bit | Condition | Status bit |
  |---|---|---|
  | [0] | overrun | 1 |
  | [1] | alignment | 4 |
  | [2] | CRC | 2 |
  | [3] | late collision | 0 |

- R9: Each descriptor close sets `evt_q[25]` at the same edge. Writing ones through `evt_wr` clears those bits. A set and a clear of bit 25 at the same edge leave the bit set.
- R10: `irq` is high whenever any bit of `evt_q` is set whose mask bit, loaded through `mask_wr`, is also set.
- R11: An `act_wr` pulse while the engine is not halted has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| rx_valid | input | 1 | a received byte is present |
| rx_data | input | 8 | received byte |
| rx_last | input | 1 | final byte of the frame |
| rx_flags | input | 4 | frame error sideband, valid with rx_last |
| act_wr | input | 1 | activate strobe |
| evt_wr | input | 1 | event register write-one-to-clear strobe |
| evt_wdata | input | 32 | bits to clear |
| mask_wr | input | 1 | mask register load strobe |
| mask_wdata | input | 32 | new mask value |
| dsc_req | output | 1 | descriptor memory access |
| dsc_we | output | 1 | descriptor write (else read, data next cycle) |
| dsc_addr | output | DESC_AW | descriptor index |
| dsc_wdata | output | 64 | descriptor write data |
| dsc_rdata | input | 64 | descriptor read data, one cycle after the read |
| buf_we | output | 1 | buffer byte write |
| buf_addr | output | 32 | buffer byte address |
| buf_wdata | output | 8 | buffer byte |
| evt_q | output | 32 | event register |
| irq | output | 1 | masked interrupt |
| drop_count | output | DROP_W | count of dropped frames |

## Verification
A descriptor close and a software clear of the event register can reach bit 25 at the same clock edge. The bench provokes this by driving the write-one-to-clear strobe in exactly the cycle after a frame's final byte. It then requires the event bit to remain set. A separate clear afterwards must bring both the bit and the interrupt back to 0.

Two other collisions are also checked:
- an activate pulse that arrives while a descriptor is already owned must leave the ring position unchanged;
- a frame that arrives during a stall must leave no buffer write behind.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int STS_EMPTY = 15;
    localparam int STS_WRAP  = 13;
    localparam int STS_LAST  = 11;
    localparam int STS_LONG  = 5;
    localparam int STS_ALIGN = 4;
    localparam int STS_SHORT = 3;
    localparam int STS_CRC   = 2;
    localparam int STS_OVR   = 1;
    localparam int STS_LCOL  = 0;

    localparam int EVT_FRAME_BIT = 25;

    typedef struct packed {
        logic [15:0] sts;
        logic [15:0] len;
        logic [31:0] addr;
    } rx_desc_t;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_FETCH,
        ST_WAIT,
        ST_READY,
        ST_RECV,
        ST_CLOSE
    } ring_state_e;

    typedef struct packed {
        logic late_coll;
        logic crc;
        logic align;
        logic overrun;
    } rx_side_t;

    typedef struct packed {
        logic     too_long;
        logic     too_short;
        rx_side_t side;
    } rx_err_t;

    function automatic logic [15:0] close_status(input logic [15:0] orig, input rx_err_t e);
        logic [15:0] s;
        s            = orig;
        s[STS_EMPTY] = 1'b0;
        s[STS_LAST]  = 1'b1;
        s[STS_LONG]  = e.too_long;
        s[STS_SHORT] = e.too_short;
        s[STS_ALIGN] = e.side.align;
        s[STS_CRC]   = e.side.crc;
        s[STS_OVR]   = e.side.overrun;
        s[STS_LCOL]  = e.side.late_coll;
        return s;
    endfunction

endpackage

// File: rtl/rxr_frame_stat.sv
module rxr_frame_stat
    import rxr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int BUF_MAX = 1520,
    parameter int FRM_MIN = 64,
    parameter int FRM_MAX = 1518
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             first,
    input  logic             last,
    input  rx_side_t         side,
    output logic [CNT_W-1:0] offset,
    output logic             in_buf,
    output logic [CNT_W-1:0] frm_len,
    output rx_err_t          err
);
    localparam logic [CNT_W-1:0] MIN_L = CNT_W'(FRM_MIN);
    localparam logic [CNT_W-1:0] MAX_L = CNT_W'(FRM_MAX);
    localparam logic [CNT_W-1:0] BUF_L = CNT_W'(BUF_MAX);
    localparam logic [CNT_W-1:0] SAT_L = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    rx_side_t         side_q;

    always_comb begin
        offset = first ? '0 : cnt_q;
        in_buf = offset < BUF_L;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            side_q <= '0;
        end else if (take) begin
            if (first)
                cnt_q <= CNT_W'(1);
            else if (cnt_q != SAT_L)
                cnt_q <= cnt_q + 1'b1;
            if (last)
                side_q <= side;
        end
    end

    always_comb begin
        frm_len       = cnt_q;
        err.too_long  = cnt_q > MAX_L;
        err.too_short = cnt_q < MIN_L;
        err.side      = side_q;
    end

endmodule

// File: rtl/rxr_evt_regs.sv
module rxr_evt_regs #(
    parameter int EVT_W   = 32,
    parameter int SET_BIT = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_pulse,
    input  logic             clr_wr,
    input  logic [EVT_W-1:0] clr_bits,
    input  logic             mask_wr,
    input  logic [EVT_W-1:0] mask_bits,
    output logic [EVT_W-1:0] evt_q,
    output logic [EVT_W-1:0] mask_q,
    output logic             irq
);
    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        logic set_i;
        logic clr_i;
        assign set_i = (i == SET_BIT) ? set_pulse : 1'b0;
        assign clr_i = clr_wr & clr_bits[i];
        always_ff @(posedge clk) begin
            if (rst)
                evt_q[i] <= 1'b0;
            else if (set_i)
                evt_q[i] <= 1'b1;
            else if (clr_i)
                evt_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (mask_wr)
            mask_q <= mask_bits;
    end

    assign irq = |(evt_q & mask_q);

endmodule

// File: rtl/rxr_ring_fsm.sv
module rxr_ring_fsm
    import rxr_pkg::*;
#(
    parameter int DESC_AW = 4,
    parameter int DROP_W  = 16,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic               rx_last,
    input  logic               act_wr,
    input  logic [63:0]        dsc_rdata,
    input  logic [15:0]        wb_sts,
    input  logic [CNT_W-1:0]   frm_len,
    output logic               take,
    output logic               first,
    output logic [15:0]        cur_sts,
    output logic [31:0]        buf_base,
    output logic               dsc_req,
    output logic               dsc_we,
    output logic [DESC_AW-1:0] dsc_addr,
    output logic [63:0]        dsc_wdata,
    output logic               close_pulse,
    output logic [DROP_W-1:0]  drop_count
);
    ring_state_e        st_q, st_d;
    logic [DESC_AW-1:0] idx_q;
    logic               mid_q;
    logic               frm_start;
    logic               drop_start;
    rx_desc_t           rd;
    rx_desc_t           wb;

    always_comb begin
        rd         = rx_desc_t'(dsc_rdata);
        frm_start  = rx_valid & ~mid_q;
        first      = frm_start & (st_q == ST_READY);
        take       = first | (rx_valid & (st_q == ST_RECV));
        drop_start = frm_start & (st_q != ST_READY);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT:  if (act_wr) st_d = ST_FETCH;
            ST_FETCH: st_d = ST_WAIT;
            ST_WAIT:  st_d = rd.sts[STS_EMPTY] ? ST_READY : ST_HALT;
            ST_READY: if (first) st_d = rx_last ? ST_CLOSE : ST_RECV;
            ST_RECV:  if (take && rx_last) st_d = ST_CLOSE;
            ST_CLOSE: st_d = ST_FETCH;
            default:  st_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_HALT;
            idx_q      <= '0;
            mid_q      <= 1'b0;
            cur_sts    <= '0;
            buf_base   <= '0;
            drop_count <= '0;
        end else begin
            st_q <= st_d;
            if (rx_valid)
                mid_q <= ~rx_last;
            if (drop_start)
                drop_count <= drop_count + 1'b1;
            if (st_q == ST_WAIT && rd.sts[STS_EMPTY]) begin
                cur_sts  <= rd.sts;
                buf_base <= rd.addr;
            end
            if (st_q == ST_CLOSE)
                idx_q <= cur_sts[STS_WRAP] ? '0 : idx_q + 1'b1;
        end
    end

    always_comb begin
        wb.sts      = wb_sts;
        wb.len      = 16'(frm_len);
        wb.addr     = buf_base;
        dsc_req     = (st_q == ST_FETCH) | (st_q == ST_CLOSE);
        dsc_we      = (st_q == ST_CLOSE);
        dsc_addr    = idx_q;
        dsc_wdata   = wb;
        close_pulse = (st_q == ST_CLOSE);
    end

endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
    import rxr_pkg::*;
#(
    parameter int DESC_AW = 4,
    parameter int DROP_W  = 16,
    parameter int BUF_MAX = 1520,
    parameter int FRM_MIN = 64,
    parameter int FRM_MAX = 1518
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    input  logic               rx_last,
    input  logic [3:0]         rx_flags,
    input  logic               act_wr,
    input  logic               evt_wr,
    input  logic [31:0]        evt_wdata,
    input  logic               mask_wr,
    input  logic [31:0]        mask_wdata,
    output logic               dsc_req,
    output logic               dsc_we,
    output logic [DESC_AW-1:0] dsc_addr,
    output logic [63:0]        dsc_wdata,
    input  logic [63:0]        dsc_rdata,
    output logic               buf_we,
    output logic [31:0]        buf_addr,
    output logic [7:0]         buf_wdata,
    output logic [31:0]        evt_q,
    output logic               irq,
    output logic [DROP_W-1:0]  drop_count
);
    localparam int CNT_W = 16;

    logic             take;
    logic             first;
    logic [15:0]      cur_sts;
    logic [15:0]      wb_sts;
    logic [31:0]      buf_base;
    logic [CNT_W-1:0] offset;
    logic [CNT_W-1:0] frm_len;
    logic             in_buf;
    logic             close_pulse;
    logic [31:0]      mask_q;
    rx_err_t          err;

    rxr_ring_fsm #(
        .DESC_AW (DESC_AW),
        .DROP_W  (DROP_W),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .rx_valid    (rx_valid),
        .rx_last     (rx_last),
        .act_wr      (act_wr),
        .dsc_rdata   (dsc_rdata),
        .wb_sts      (wb_sts),
        .frm_len     (frm_len),
        .take        (take),
        .first       (first),
        .cur_sts     (cur_sts),
        .buf_base    (buf_base),
        .dsc_req     (dsc_req),
        .dsc_we      (dsc_we),
        .dsc_addr    (dsc_addr),
        .dsc_wdata   (dsc_wdata),
        .close_pulse (close_pulse),
        .drop_count  (drop_count)
    );

    rxr_frame_stat #(
        .CNT_W   (CNT_W),
        .BUF_MAX (BUF_MAX),
        .FRM_MIN (FRM_MIN),
        .FRM_MAX (FRM_MAX)
    ) u_stat (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .first   (first),
        .last    (rx_last),
        .side    (rx_side_t'(rx_flags)),
        .offset  (offset),
        .in_buf  (in_buf),
        .frm_len (frm_len),
        .err     (err)
    );

    rxr_evt_regs #(
        .EVT_W   (32),
        .SET_BIT (EVT_FRAME_BIT)
    ) u_evt (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (close_pulse),
        .clr_wr    (evt_wr),
        .clr_bits  (evt_wdata),
        .mask_wr   (mask_wr),
        .mask_bits (mask_wdata),
        .evt_q     (evt_q),
        .mask_q    (mask_q),
        .irq       (irq)
    );

    always_comb begin
        wb_sts    = close_status(cur_sts, err);
        buf_we    = take & in_buf;
        buf_addr  = buf_base + {16'b0, offset};
        buf_wdata = rx_data;
    end

endmodule

// File: rtl/rxring_engine_chk.sv
module rxring_engine_chk #(
    parameter int DROP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              dsc_req,
    input logic              dsc_we,
    input logic [63:0]       dsc_wdata,
    input logic              buf_we,
    input logic [31:0]       evt_q,
    input logic [31:0]       mask_q,
    input logic              mask_wr,
    input logic              irq,
    input logic [DROP_W-1:0] drop_count
);
    // R3: a write-back hands the descriptor back with last set
    assert_wb_owner_R3: assert property (@(posedge clk) disable iff (rst)
        dsc_we |-> (!dsc_wdata[63] && dsc_wdata[59]));

    // R3: a closed frame never reports zero length
    assert_wb_len_R3: assert property (@(posedge clk) disable iff (rst)
        dsc_we |-> (dsc_wdata[47:32] != 16'd0));

    // R2: buffer and descriptor traffic never share a cycle
    assert_no_buf_on_dsc_R2: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> !dsc_req);

    // R9: the close edge leaves the frame event set
    assert_evt_after_close_R9: assert property (@(posedge clk) disable iff (rst)
        dsc_we |=> evt_q[25]);

    // R10: an unmasked close drives the interrupt
    assert_irq_after_close_R10: assert property (@(posedge clk) disable iff (rst)
        (dsc_we && mask_q[25] && !mask_wr) |=> irq);

    // R5: the drop counter only ever steps by one
    assert_drop_step_R5: assert property (@(posedge clk) disable iff (rst)
        (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));

endmodule

bind rxring_engine rxring_engine_chk #(.DROP_W(DROP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dsc_req    (dsc_req),
    .dsc_we     (dsc_we),
    .dsc_wdata  (dsc_wdata),
    .buf_we     (buf_we),
    .evt_q      (evt_q),
    .mask_q     (mask_q),
    .mask_wr    (mask_wr),
    .irq        (irq),
    .drop_count (drop_count)
);

// File: tb/rxring_engine_bench.sv
module rxring_engine_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic [3:0]  rx_flags = '0;
    logic        act_wr = 1'b0;
    logic        evt_wr = 1'b0;
    logic [31:0] evt_wdata = '0;
    logic        mask_wr = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic        dsc_req;
    logic        dsc_we;
    logic [3:0]  dsc_addr;
    logic [63:0] dsc_wdata;
    logic [63:0] dsc_rdata = '0;
    logic        buf_we;
    logic [31:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic [31:0] evt_q;
    logic        irq;
    logic [15:0] drop_count;

    logic [63:0] desc_mem [0:15];
    logic [7:0]  buf_mem  [0:8191];
    int          checks = 0;
    int          errors = 0;
    int          bufwr_count = 0;
    int          dscreq_count = 0;

    always #2.5 clk = ~clk;

    rxring_engine u_rxring_engine (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .rx_flags   (rx_flags),
        .act_wr     (act_wr),
        .evt_wr     (evt_wr),
        .evt_wdata  (evt_wdata),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .dsc_req    (dsc_req),
        .dsc_we     (dsc_we),
        .dsc_addr   (dsc_addr),
        .dsc_wdata  (dsc_wdata),
        .dsc_rdata  (dsc_rdata),
        .buf_we     (buf_we),
        .buf_addr   (buf_addr),
        .buf_wdata  (buf_wdata),
        .evt_q      (evt_q),
        .irq        (irq),
        .drop_count (drop_count)
    );

    always @(posedge clk) begin
        if (dsc_req) begin
            dscreq_count <= dscreq_count + 1;
            if (dsc_we)
                desc_mem[dsc_addr] <= dsc_wdata;
            else
                dsc_rdata <= desc_mem[dsc_addr];
        end
        if (buf_we) begin
            buf_mem[buf_addr[12:0]] <= buf_wdata;
            bufwr_count <= bufwr_count + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_desc(input int idx, input logic [15:0] sts, input logic [31:0] addr);
        desc_mem[idx] = {sts, 16'h0000, addr};
    endtask

    task automatic activate();
        @(negedge clk); act_wr = 1'b1;
        @(negedge clk); act_wr = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed, input logic [3:0] flg, input bit clr_at_close);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'(seed + 8'(i));
            rx_last  = (i == len - 1);
            rx_flags = (i == len - 1) ? flg : 4'h0;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_flags = 4'h0;
        if (clr_at_close) begin
            evt_wr = 1'b1; evt_wdata = 32'h0200_0000;
        end
        @(negedge clk);
        evt_wr = 1'b0; evt_wdata = '0;
        repeat (6) @(negedge clk);
    endtask

    function automatic int buf_mismatch(input int base, input int len, input logic [7:0] seed);
        int bad = 0;
        for (int i = 0; i < len && i < 1520; i++)
            if (buf_mem[base + i] !== 8'(seed + 8'(i))) bad++;
        return bad;
    endfunction

    task automatic t_reset();
        repeat (6) @(negedge clk);
        chk(evt_q == 32'h0, "R1 event after reset", 64'(evt_q), 64'h0);
        chk(irq == 1'b0, "R1 irq after reset", 64'(irq), 64'h0);
        chk(drop_count == 16'h0, "R1 drop count after reset", 64'(drop_count), 64'h0);
        chk(dscreq_count == 0 && bufwr_count == 0, "R1 no access while halted",
            64'(dscreq_count + bufwr_count), 64'h0);
    endtask

    task automatic t_basic_and_wrap();
        set_desc(0, 16'h8000, 32'h0000_0100);
        set_desc(1, 16'hA000, 32'h0000_0800);
        activate();
        send_frame(70, 8'h10, 4'h0, 1'b0);
        chk(desc_mem[0] == {16'h0800, 16'd70, 32'h0000_0100}, "R3 close desc0", desc_mem[0],
            {16'h0800, 16'd70, 32'h0000_0100});
        chk(buf_mismatch(32'h100, 70, 8'h10) == 0, "R2 buffer bytes frame A",
            64'(buf_mismatch(32'h100, 70, 8'h10)), 64'h0);
        chk(evt_q[25] == 1'b1, "R9 event set by close", 64'(evt_q), 64'h0200_0000);
        send_frame(100, 8'h55, 4'h0, 1'b0);
        chk(desc_mem[1] == {16'h2800, 16'd100, 32'h0000_0800}, "R4 next index and R3 wrap kept",
            desc_mem[1], {16'h2800, 16'd100, 32'h0000_0800});
        chk(buf_mismatch(32'h800, 100, 8'h55) == 0, "R2 buffer bytes frame B",
            64'(buf_mismatch(32'h800, 100, 8'h55)), 64'h0);
    endtask

    task automatic t_halt_drop();
        int wr_before = bufwr_count;
        send_frame(30, 8'h99, 4'h0, 1'b0);
        chk(drop_count == 16'd1, "R5 dropped frame counted", 64'(drop_count), 64'h1);
        chk(bufwr_count == wr_before, "R5 no buffer write while halted",
            64'(bufwr_count), 64'(wr_before));
        chk(desc_mem[0][63:48] == 16'h0800, "R5 owned descriptor untouched",
            64'(desc_mem[0][63:48]), 64'h0800);
    endtask

    task automatic t_resume_short();
        set_desc(0, 16'h8000, 32'h0000_1000);
        set_desc(1, 16'hA000, 32'h0000_1400);
        activate();
        send_frame(20, 8'h20, 4'b0110, 1'b0);
        chk(desc_mem[0] == {16'h081C, 16'd20, 32'h0000_1000}, "R6 re-read index 0, R7 short, R8 flags",
            desc_mem[0], {16'h081C, 16'd20, 32'h0000_1000});
        chk(buf_mismatch(32'h1000, 20, 8'h20) == 0, "R6 bytes after resume",
            64'(buf_mismatch(32'h1000, 20, 8'h20)), 64'h0);
    endtask

    task automatic t_long_ignore_act();
        for (int i = 0; i < 16; i++) buf_mem[32'h1400 + 1510 + i] = 8'hEE;
        @(negedge clk); act_wr = 1'b1;
        @(negedge clk); act_wr = 1'b0;
        send_frame(1530, 8'h03, 4'b1001, 1'b0);
        chk(desc_mem[1] == {16'h2823, 16'd1530, 32'h0000_1400}, "R11 act ignored, R7 long, R8 flags",
            desc_mem[1], {16'h2823, 16'd1530, 32'h0000_1400});
        chk(buf_mem[32'h1400 + 1519] == 8'(8'h03 + 8'(1519)), "R7 last byte inside buffer",
            64'(buf_mem[32'h1400 + 1519]), 64'(8'(8'h03 + 8'(1519))));
        chk(buf_mem[32'h1400 + 1520] == 8'hEE, "R7 no write past buffer",
            64'(buf_mem[32'h1400 + 1520]), 64'hEE);
    endtask

    task automatic t_event_irq();
        chk(irq == 1'b0, "R10 irq masked off", 64'(irq), 64'h0);
        @(negedge clk); mask_wr = 1'b1; mask_wdata = 32'h0200_0000;
        @(negedge clk); mask_wr = 1'b0;
        chk(irq == 1'b1, "R10 irq after unmask", 64'(irq), 64'h1);
        @(negedge clk); evt_wr = 1'b1; evt_wdata = 32'hFFFF_FFFF;
        @(negedge clk); evt_wr = 1'b0; evt_wdata = '0;
        chk(evt_q == 32'h0, "R9 write-one clears", 64'(evt_q), 64'h0);
        chk(irq == 1'b0, "R10 irq after clear", 64'(irq), 64'h0);
    endtask

    task automatic t_coincide();
        set_desc(0, 16'h8000, 32'h0000_1A00);
        activate();
        send_frame(64, 8'h70, 4'h0, 1'b1);
        chk(evt_q[25] == 1'b1, "R9 set wins over same-edge clear", 64'(evt_q), 64'h0200_0000);
        chk(desc_mem[0] == {16'h0800, 16'd64, 32'h0000_1A00}, "R7 64 bytes not short",
            desc_mem[0], {16'h0800, 16'd64, 32'h0000_1A00});
        chk(irq == 1'b1, "R10 irq on coincident close", 64'(irq), 64'h1);
        @(negedge clk); evt_wr = 1'b1; evt_wdata = 32'h0200_0000;
        @(negedge clk); evt_wr = 1'b0; evt_wdata = '0;
        chk(evt_q[25] == 1'b0 && irq == 1'b0, "R9 later clear", 64'({evt_q, 31'b0, irq}), 64'h0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) desc_mem[i] = '0;
        for (int i = 0; i < 8192; i++) buf_mem[i] = 8'hEE;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic_and_wrap();
        t_halt_drop();
        t_resume_short();
        t_long_ignore_act();
        t_event_irq();
        t_coincide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule